// File: doc/BRIEF.md
# Packed-Decimal Digit Stream Sequencer

This block plays out a long fixed sequence of decimal digits, such as the digits of pi, on one 7-segment display at a rate of one symbol per clock. The digits sit in an external word store, three to a word, as 10-bit densely packed decimal (DPD) words. The block presents a triplet address to the store and reads the returned word combinationally in the same cycle. It unpacks that word into three BCD digits and uses the low field of its index counter to pick one. It then drives the segment lines for that digit.

A 12-bit index counter sequences the stream. Its upper ten bits address the word. Its lower two bits pick the digit inside the word and only take the values 0, 1 and 2. A decimal-point symbol appears once per pass, straight after the leading digit. During that symbol the counter stalls for one clock. After the final digit of the sequence the counter returns to zero and the decimal point is armed again, so the display loops for as long as the clock runs. The segment outputs and the address are combinational functions of the registered counter state.

Top module: `digit_stream_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release, the block presents address 0, shows the leading digit of word 0, and holds `dp_led` low.
- R2: Each stored word is unpacked by the standard DPD-to-BCD mapping. Bits 9..0 are named p q r s t u v w x y, and the mapping covers every indicator case where any of the three digits is 8 or 9. Digit 0 of a word is its most significant decimal digit.
- R3: `word_addr` equals the number of the word that holds the digit on display. Between two cycles it either stays the same, rises by one, or returns to 0.
- R4: Within a word the digits appear in the order 0, 1, 2. The next cycle then shows digit 0 of the following word, so the address rises by one after every three digit cycles.
- R5: Exactly one decimal-point cycle occurs per pass, directly after digit 0 of word 0. In it `seg` is all zeros and `dp_led` is 1.
- R6: During the decimal-point cycle the counter holds, `word_addr` stays 0, and the next cycle shows digit 1 of word 0.
- R7: For an ordinary digit `dp_led` is 0. `seg` is active high with bit 0 = a up to bit 6 = g, using the patterns 0:0x3F 1:0x06 2:0x5B 3:0x4F 4:0x66 5:0x6D 6:0x7D 7:0x07 8:0x7F 9:0x6F.
- R8: After the last digit of the sequence (digit `NUM_DIGITS-1`), the next cycle shows digit 0 of word 0 again, and the decimal point follows it once more.
- R9: A reset applied mid-stream, including during the decimal-point cycle, restarts the sequence from digit 0 and re-arms the decimal point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a falling clock edge |
| word_addr | output | 10 | Address of the packed word in the external store |
| word_in | input | 10 | Packed DPD word returned for `word_addr` in the same cycle |
| seg | output | 7 | Segment lines a..g, active high, bit 0 = a |
| dp_led | output | 1 | Decimal LED, high only in the decimal-point cycle |

## Verification
Two functions can act at the same clock edge. The wrap from the final digit back to zero re-arms the decimal point. Reset can also land while the decimal point is on display and the counter is stalled. The bench runs the stream twice past its end, so the wrap is followed at once by a fresh digit 0 and a single decimal point. It then pulses reset exactly in a decimal-point cycle. In both cases a behavioural model of the expected symbol sequence is compared with address, segments and LED on every clock.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

  typedef logic [3:0] bcd_t;
  typedef logic [6:0] seg_t;

  // Active-high segment pattern, bit 0 = a ... bit 6 = g.
  function automatic seg_t bcd_to_seg(input bcd_t d);
    seg_t s;
    case (d)
      4'd0:    s = 7'h3F;
      4'd1:    s = 7'h06;
      4'd2:    s = 7'h5B;
      4'd3:    s = 7'h4F;
      4'd4:    s = 7'h66;
      4'd5:    s = 7'h6D;
      4'd6:    s = 7'h7D;
      4'd7:    s = 7'h07;
      4'd8:    s = 7'h7F;
      4'd9:    s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/dsq_dpd_decode.sv
module dsq_dpd_decode
  import dsq_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic [WORD_W-1:0] word,
  output bcd_t              dig_hi,
  output bcd_t              dig_mid,
  output bcd_t              dig_lo
);

  logic p, q, r, s, t, u, v, w, x, y;

  always_comb begin
    {p, q, r, s, t, u, v, w, x, y} = word[9:0];
    dig_hi  = {1'b0, p, q, r};
    dig_mid = {1'b0, s, t, u};
    dig_lo  = {1'b0, w, x, y};
    if (v) begin
      case ({w, x})
        2'b00: dig_lo = {3'b100, y};
        2'b01: begin
          dig_mid = {3'b100, u};
          dig_lo  = {1'b0, s, t, y};
        end
        2'b10: begin
          dig_hi = {3'b100, r};
          dig_lo = {1'b0, p, q, y};
        end
        default: begin
          case ({s, t})
            2'b00: begin
              dig_hi  = {3'b100, r};
              dig_mid = {3'b100, u};
              dig_lo  = {1'b0, p, q, y};
            end
            2'b01: begin
              dig_hi  = {3'b100, r};
              dig_mid = {1'b0, p, q, u};
              dig_lo  = {3'b100, y};
            end
            2'b10: begin
              dig_mid = {3'b100, u};
              dig_lo  = {3'b100, y};
            end
            default: begin
              dig_hi  = {3'b100, r};
              dig_mid = {3'b100, u};
              dig_lo  = {3'b100, y};
            end
          endcase
        end
      endcase
    end
  end

endmodule

// File: rtl/dsq_index_seq.sv
module dsq_index_seq #(
  parameter int IDX_W      = 12,
  parameter int SEL_W      = 2,
  parameter int NUM_DIGITS = 1400
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [IDX_W-1:0] idx_q,
  output logic             dp_q
);

  localparam int DIG_PER_WORD = 3;
  localparam int LAST_WORD    = (NUM_DIGITS - 1) / DIG_PER_WORD;
  localparam int LAST_SEL     = (NUM_DIGITS - 1) % DIG_PER_WORD;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'((LAST_WORD << SEL_W) + LAST_SEL);
  localparam logic [SEL_W-1:0] TOP_SEL  = SEL_W'(DIG_PER_WORD - 1);

  logic [IDX_W-1:0] idx_d;
  logic             idx_en;
  logic             armed_q, armed_d;
  logic             dp_d;
  logic             at_last, at_top;

  always_comb begin
    at_last = (idx_q == LAST_IDX);
    at_top  = (idx_q[SEL_W-1:0] == TOP_SEL);
    idx_en  = !dp_q;
    if (at_last)     idx_d = '0;
    else if (at_top) idx_d = idx_q + IDX_W'(2);
    else             idx_d = idx_q + IDX_W'(1);
    dp_d = !dp_q && armed_q && (idx_q == '0);
    if (dp_q)         armed_d = 1'b0;
    else if (at_last) armed_d = 1'b1;
    else              armed_d = armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      dp_q    <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      if (idx_en) idx_q <= idx_d;
      dp_q    <= dp_d;
      armed_q <= armed_d;
    end
  end

endmodule

// File: rtl/dsq_digit_out.sv
module dsq_digit_out
  import dsq_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  bcd_t             dig_hi,
  input  bcd_t             dig_mid,
  input  bcd_t             dig_lo,
  input  logic [SEL_W-1:0] sel,
  input  logic             show_dp,
  output seg_t             seg,
  output logic             dp_led
);

  bcd_t picked;

  always_comb begin
    case (sel)
      SEL_W'(0): picked = dig_hi;
      SEL_W'(1): picked = dig_mid;
      default:   picked = dig_lo;
    endcase
    if (show_dp) begin
      seg    = '0;
      dp_led = 1'b1;
    end else begin
      seg    = bcd_to_seg(picked);
      dp_led = 1'b0;
    end
  end

endmodule

// File: rtl/digit_stream_seq.sv
module digit_stream_seq
  import dsq_pkg::*;
#(
  parameter int IDX_W      = 12,
  parameter int SEL_W      = 2,
  parameter int WORD_W     = 10,
  parameter int NUM_DIGITS = 1400
) (
  input  logic                     clk,
  input  logic                     rst_n,
  output logic [IDX_W-SEL_W-1:0]   word_addr,
  input  logic [WORD_W-1:0]        word_in,
  output logic [6:0]               seg,
  output logic                     dp_led
);

  logic [IDX_W-1:0] idx_q;
  logic             dp_q;
  bcd_t             dig_hi, dig_mid, dig_lo;

  dsq_index_seq #(
    .IDX_W      (IDX_W),
    .SEL_W      (SEL_W),
    .NUM_DIGITS (NUM_DIGITS)
  ) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .idx_q (idx_q),
    .dp_q  (dp_q)
  );

  assign word_addr = idx_q[IDX_W-1:SEL_W];

  dsq_dpd_decode #(
    .WORD_W (WORD_W)
  ) u_dec (
    .word    (word_in),
    .dig_hi  (dig_hi),
    .dig_mid (dig_mid),
    .dig_lo  (dig_lo)
  );

  dsq_digit_out #(
    .SEL_W (SEL_W)
  ) u_out (
    .dig_hi  (dig_hi),
    .dig_mid (dig_mid),
    .dig_lo  (dig_lo),
    .sel     (idx_q[SEL_W-1:0]),
    .show_dp (dp_q),
    .seg     (seg),
    .dp_led  (dp_led)
  );

endmodule

// File: rtl/dsq_checker.sv
module dsq_checker #(
  parameter int IDX_W      = 12,
  parameter int SEL_W      = 2,
  parameter int NUM_DIGITS = 1400
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [IDX_W-1:0]       idx_q,
  input logic [IDX_W-SEL_W-1:0] word_addr,
  input logic [6:0]             seg,
  input logic                   dp_led
);

  localparam int ADDR_W    = IDX_W - SEL_W;
  localparam int LAST_WORD = (NUM_DIGITS - 1) / 3;
  localparam int LAST_SEL  = (NUM_DIGITS - 1) % 3;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'((LAST_WORD << SEL_W) + LAST_SEL);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (idx_q == '0 && !dp_led));

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_addr != $past(word_addr)) |->
      (word_addr == $past(word_addr) + ADDR_W'(1) || word_addr == '0));

  assert_low_field_R4: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q[SEL_W-1:0] != SEL_W'(3));

  assert_dp_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dp_led |-> (seg == 7'h00));

  assert_dp_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dp_led |=> !dp_led);

  assert_dp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dp_led |-> (word_addr == '0));

  assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q == LAST_IDX && !dp_led) |=> (idx_q == '0 && !dp_led));

endmodule

bind digit_stream_seq dsq_checker #(
  .IDX_W      (IDX_W),
  .SEL_W      (SEL_W),
  .NUM_DIGITS (NUM_DIGITS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .idx_q     (idx_q),
  .word_addr (word_addr),
  .seg       (seg),
  .dp_led    (dp_led)
);

// File: tb/digit_stream_seq_tb.sv
module digit_stream_seq_tb;

  localparam int N     = 1400;
  localparam int CYCLE = N + 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] word_addr;
  logic [9:0] word_in;
  logic [6:0] seg;
  logic       dp_led;

  int checks = 0;
  int errors = 0;
  int ptr = 0;
  int cyc = 0;
  string rst_tag = "R1";

  always #2 clk = ~clk;

  digit_stream_seq u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_addr (word_addr),
    .word_in   (word_in),
    .seg       (seg),
    .dp_led    (dp_led)
  );

  // Three-digit value stored in word t (digit 0 is the hundreds digit).
  function automatic int word_value(input int t);
    if (t == 0) return 314;
    return (t * 7919 + 123) % 1000;
  endfunction

  function automatic int digit_at(input int k);
    int v;
    v = word_value(k / 3);
    case (k % 3)
      0:       return v / 100;
      1:       return (v / 10) % 10;
      default: return v % 10;
    endcase
  endfunction

  // BCD to densely packed decimal, bits p q r s t u v w x y = 9..0.
  function automatic logic [9:0] pack3(input int val);
    logic [3:0] a, b, c;
    logic [9:0] o;
    a = 4'(val / 100); b = 4'((val / 10) % 10); c = 4'(val % 10);
    case ({a[3], b[3], c[3]})
      3'b000: o = {a[2:0], b[2:0], 1'b0, c[2:0]};
      3'b001: o = {a[2:0], b[2:0], 1'b1, 2'b00, c[0]};
      3'b010: o = {a[2:0], c[2:1], b[0], 1'b1, 2'b01, c[0]};
      3'b100: o = {c[2:1], a[0], b[2:0], 1'b1, 2'b10, c[0]};
      3'b011: o = {a[2:0], 2'b10, b[0], 1'b1, 2'b11, c[0]};
      3'b101: o = {b[2:1], a[0], 2'b01, b[0], 1'b1, 2'b11, c[0]};
      3'b110: o = {c[2:1], a[0], 2'b00, b[0], 1'b1, 2'b11, c[0]};
      default: o = {2'b00, a[0], 2'b11, b[0], 1'b1, 2'b11, c[0]};
    endcase
    return o;
  endfunction

  function automatic logic [6:0] seg_ref(input int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  // External word store model.
  always_comb begin
    if (int'(word_addr) <= (N - 1) / 3) word_in = pack3(word_value(int'(word_addr)));
    else                                 word_in = '0;
  end

  // Reference: symbol position in the looping stream d0, DP, d1 ... d(N-1).
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) ptr <= 0;
    else        ptr <= (ptr + 1) % CYCLE;
  end

  task automatic check_now();
    int k;
    logic [9:0] exp_addr;
    logic [6:0] exp_seg;
    logic       exp_dp;
    string      tag;
    if (ptr == 1) begin
      k = 0; exp_seg = 7'h00; exp_dp = 1'b1; tag = "R5";
    end else begin
      k = (ptr == 0) ? 0 : ptr - 1;
      exp_seg = seg_ref(digit_at(k)); exp_dp = 1'b0;
      if (ptr == 0)             tag = rst_n ? "R8" : rst_tag;
      else if (ptr == 2)        tag = "R6";
      else if (digit_at(k) >= 8) tag = "R2";
      else if (k % 3 == 0)      tag = "R4";
      else                      tag = "R7";
    end
    exp_addr = 10'(k / 3);
    checks++;
    if (seg !== exp_seg || dp_led !== exp_dp) begin
      errors++;
      $display("FAIL %s pos %0d: seg=%h dp=%b expected seg=%h dp=%b",
               tag, ptr, seg, dp_led, exp_seg, exp_dp);
    end
    checks++;
    if (word_addr !== exp_addr) begin
      errors++;
      $display("FAIL R3 pos %0d: word_addr=%0d expected %0d", ptr, word_addr, exp_addr);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_now();
    end
  endtask

  task automatic pulse_reset(input string tag);
    rst_tag = tag;
    rst_n = 1'b0;
    run(2);
    rst_n = 1'b1;
  endtask

  initial begin
    run(3);                       // R1: reset state
    rst_n = 1'b1;
    run(2 * CYCLE + 6);           // two wraps, R8 and repeated decimal point
    while (ptr != 1) run(1);      // stop in a decimal-point cycle
    pulse_reset("R9");            // R9: reset during the decimal point
    run(40);
    pulse_reset("R9");            // R9: reset mid-stream
    run(10);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #40000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule